// File: doc/BRIEF.md
# Coarse-Grain Thread Switch Controller

This block steers the front end of a five-stage in-order pipeline that holds two hardware thread contexts. Only one thread fetches and issues at a time. Apart from the thread that is running, the pipeline behaves exactly like a single-thread pipeline. Each context keeps its own program counter, and the active thread ID picks the register file. The pipeline stages and the caches are shared between the two threads.

The controller changes thread only when a long-latency event occurs. The first such event is an instruction-cache miss reported by fetch. The second is a data-cache miss reported by the memory stage, which also supplies the thread ID and the PC of the faulting instruction. On a data-cache miss, every younger instruction of that thread still in the front stages is squashed, and that thread's PC is rewound so the faulting instruction runs again. A thread with an outstanding miss stays parked until its miss-resolved input pulses. If both threads are parked, fetch issues bubbles.

The outputs are the active thread ID, a fetch-valid flag, the fetch PC and one flush bit for each front stage. Bit 0 is the fetch stage, and higher bits are the stages that follow it, up to and including execute.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset, thread 0 is active, fetch_valid_o is 1, fetch_pc_o equals RESET_PC0, flush_o is 0, and thread 1 waits at RESET_PC1 with no miss outstanding.
- R2: While fetch_valid_o is 1 and no miss hits the active thread, the active thread stays the same and fetch_pc_o grows by PC_STEP every cycle.
- R3: An instruction-cache miss while fetch_valid_o is 1 sets flush_o[0] in the same cycle and parks the active thread at the missing address. If the other thread is free, that thread fetches from its own saved PC in the next cycle.
- R4: A data-cache miss for thread t sets flush_o[k] (k ≥ 1) in the same cycle, for exactly those stages that hold a valid instruction of thread t. It also sets flush_o[0] when t is the fetching thread. Instructions of the other thread and bubbles are never flushed.
- R5: After a data-cache miss for thread t, thread t's saved PC equals dc_miss_pc_i. When t next runs, it fetches that address first.
- R6: A data-cache miss for the active thread parks it. The other thread becomes active in the next cycle if it is free.
- R7: A parked thread is never selected until its resolve_i bit pulses. A pulse is honoured in the same cycle it arrives. While both threads are parked, fetch_valid_o is 0.
- R8: An instruction-cache miss and a data-cache miss of the active thread in the same cycle cause one switch. The parked thread's saved PC is dc_miss_pc_i, not the instruction-cache miss address.
- R9: A data-cache miss for the thread that is not active leaves the active thread, its PC progression and flush_o[0] unchanged.
- R10: When fetch has been idle and both threads become free in the same cycle, the thread that was not the last one active is chosen.
- R11: ic_miss_i has no effect while fetch_valid_o is 0. No flush is raised and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ic_miss_i | input | 1 | Instruction-cache miss on the current fetch |
| dc_miss_i | input | 1 | Data-cache miss in the memory stage |
| dc_miss_tid_i | input | 1 | Thread ID of the missing load or store |
| dc_miss_pc_i | input | PC_W | PC of the missing load or store |
| resolve_i | input | 2 | One bit per thread: its outstanding miss has been serviced |
| active_tid_o | output | 1 | Thread currently selected for fetch and register-file access |
| fetch_valid_o | output | 1 | Fetch carries a real instruction (0 = bubble) |
| fetch_pc_o | output | PC_W | Address to fetch |
| flush_o | output | NSTG | Per-stage squash, bit 0 = fetch, highest = execute |

## Verification
The bench builds the controller with a 16-bit PC, a step of 4, distinct reset PCs 0x0100 and 0x0800, and three tracked front stages. These narrow widths keep every rewind address and stage occupancy easy to read. They still cover the full fetch/decode/execute squash pattern for a mix of the two threads. A directed sequence then drives several corner cases:
- rewinds of an inactive thread while the other thread runs;
- a combined instruction and data miss that leaves both threads parked;
- both threads resolving in the same cycle;
- a resolve that arrives in the same cycle as a switch.

A long pseudo-random phase then interleaves misses and resolutions against the behavioural model.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
   localparam int unsigned THREADS = 2;

   typedef logic tid_t;

   typedef struct packed {
      logic valid;
      tid_t tid;
   } slot_t;
endpackage

// File: rtl/cgmt_thread_ctx.sv
module cgmt_thread_ctx #(
   parameter int unsigned           PC_W     = 32,
   parameter int unsigned           PC_STEP  = 4,
   parameter logic [PC_W-1:0]       RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv_i,
   input  logic            rewind_i,
   input  logic [PC_W-1:0] rewind_pc_i,
   input  logic            park_i,
   input  logic            resolve_i,
   output logic [PC_W-1:0] pc_o,
   output logic            parked_o,
   output logic            parked_nxt_o
);
   localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

   logic [PC_W-1:0] pc_q;
   logic            park_q;

   // a new park request wins over a simultaneous resolve
   assign parked_nxt_o = park_i | (park_q & ~resolve_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC;
         park_q <= 1'b0;
      end else begin
         if (rewind_i)   pc_q <= rewind_pc_i;
         else if (adv_i) pc_q <= pc_q + STEP;
         park_q <= parked_nxt_o;
      end
   end

   assign pc_o     = pc_q;
   assign parked_o = park_q;

   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !rewind_i |=> pc_o == $past(pc_o) + STEP);
   a_r5_rewind_pc: assert property (@(posedge clk) disable iff (!rst_n)
      rewind_i |=> pc_o == $past(rewind_pc_i));
   a_r3_hold_on_park: assert property (@(posedge clk) disable iff (!rst_n)
      park_i && !rewind_i && !adv_i |=> pc_o == $past(pc_o));
   a_r7_stay_parked: assert property (@(posedge clk) disable iff (!rst_n)
      parked_o && !resolve_i |=> parked_o);
endmodule

// File: rtl/cgmt_sched.sv
module cgmt_sched
   import cgmt_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         switch_req_i,
   input  logic [THREADS-1:0] parked_nxt_i,
   output tid_t         act_o,
   output logic         run_o
);
   tid_t act_q, act_d, other;
   logic run_q, run_d;

   assign other = ~act_q;

   always_comb begin
      act_d = act_q;
      run_d = run_q;
      if (run_q) begin
         if (switch_req_i) begin
            if (!parked_nxt_i[other]) act_d = other;
            else                      run_d = 1'b0;
         end
      end else begin
         // idle: favour the thread that did not run last
         if (!parked_nxt_i[other]) begin
            act_d = other;
            run_d = 1'b1;
         end else if (!parked_nxt_i[act_q]) begin
            run_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         run_q <= 1'b1;
      end else begin
         act_q <= act_d;
         run_q <= run_d;
      end
   end

   assign act_o = act_q;
   assign run_o = run_q;

   a_r6_switch_taken: assert property (@(posedge clk) disable iff (!rst_n)
      run_o && switch_req_i && !parked_nxt_i[~act_o] |=> run_o && act_o != $past(act_o));
   a_r7_both_parked_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (&parked_nxt_i) |=> !run_o);
   a_r2_no_spurious_switch: assert property (@(posedge clk) disable iff (!rst_n)
      run_o && !switch_req_i |=> run_o && act_o == $past(act_o));
endmodule

// File: rtl/cgmt_stage_track.sv
module cgmt_stage_track
   import cgmt_pkg::*;
#(
   parameter int unsigned NSTG = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            if_valid_i,
   input  tid_t            if_tid_i,
   input  logic            kill_if_i,
   input  logic            dc_miss_i,
   input  tid_t            dc_tid_i,
   output logic [NSTG-1:0] flush_o
);
   slot_t pipe_q [1:NSTG-1];

   assign flush_o[0] = kill_if_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 1; k < NSTG; k++) pipe_q[k] <= '0;
      end else begin
         pipe_q[1] <= '{valid: if_valid_i && !flush_o[0], tid: if_tid_i};
         for (int k = 2; k < NSTG; k++)
            pipe_q[k] <= '{valid: pipe_q[k-1].valid && !flush_o[k-1], tid: pipe_q[k-1].tid};
      end
   end

   for (genvar k = 1; k < NSTG; k++) begin : g_flush
      assign flush_o[k] = pipe_q[k].valid && dc_miss_i && (pipe_q[k].tid == dc_tid_i);
   end

   a_r3_fetch_kill_drops: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o[0] |=> !pipe_q[1].valid);

   for (genvar k = 1; k + 1 < NSTG; k++) begin : g_chk
      a_r4_squash_drops: assert property (@(posedge clk) disable iff (!rst_n)
         flush_o[k] |=> !pipe_q[k+1].valid);
   end
endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl
   import cgmt_pkg::*;
#(
   parameter int unsigned     PC_W      = 32,
   parameter int unsigned     PC_STEP   = 4,
   parameter logic [PC_W-1:0] RESET_PC0 = '0,
   parameter logic [PC_W-1:0] RESET_PC1 = PC_W'(32'h0000_1000),
   parameter int unsigned     NSTG      = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ic_miss_i,
   input  logic            dc_miss_i,
   input  logic            dc_miss_tid_i,
   input  logic [PC_W-1:0] dc_miss_pc_i,
   input  logic [1:0]      resolve_i,
   output logic            active_tid_o,
   output logic            fetch_valid_o,
   output logic [PC_W-1:0] fetch_pc_o,
   output logic [NSTG-1:0] flush_o
);
   if (PC_W < 4) begin : g_bad_pcw
      $error("PC_W must be at least 4");
   end
   if (PC_STEP == 0 || (PC_STEP & (PC_STEP - 1)) != 0) begin : g_bad_step
      $error("PC_STEP must be a power of two");
   end
   if ((RESET_PC0 % PC_STEP) != 0 || (RESET_PC1 % PC_STEP) != 0) begin : g_bad_rpc
      $error("reset PCs must be aligned to PC_STEP");
   end
   if (NSTG < 2) begin : g_bad_nstg
      $error("NSTG must cover fetch and at least one later stage");
   end

   tid_t              act;
   logic              run;
   logic              dc_on_act;
   logic              kill_if;
   logic [THREADS-1:0] parked, parked_nxt;
   logic [PC_W-1:0]   pc_t [THREADS];

   assign dc_on_act = dc_miss_i && (dc_miss_tid_i == act);
   assign kill_if   = run && (ic_miss_i || dc_on_act);

   for (genvar t = 0; t < THREADS; t++) begin : g_ctx
      localparam logic [PC_W-1:0] RPC = (t == 0) ? RESET_PC0 : RESET_PC1;
      logic mine, rewind;
      assign mine   = run && (act == tid_t'(t));
      assign rewind = dc_miss_i && (dc_miss_tid_i == tid_t'(t));

      cgmt_thread_ctx #(
         .PC_W     (PC_W),
         .PC_STEP  (PC_STEP),
         .RESET_PC (RPC)
      ) i_ctx (
         .clk          (clk),
         .rst_n        (rst_n),
         .adv_i        (mine && !ic_miss_i && !rewind),
         .rewind_i     (rewind),
         .rewind_pc_i  (dc_miss_pc_i),
         .park_i       (rewind || (mine && ic_miss_i)),
         .resolve_i    (resolve_i[t]),
         .pc_o         (pc_t[t]),
         .parked_o     (parked[t]),
         .parked_nxt_o (parked_nxt[t])
      );
   end

   cgmt_sched i_sched (
      .clk          (clk),
      .rst_n        (rst_n),
      .switch_req_i (kill_if),
      .parked_nxt_i (parked_nxt),
      .act_o        (act),
      .run_o        (run)
   );

   cgmt_stage_track #(.NSTG(NSTG)) i_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .if_valid_i (run),
      .if_tid_i   (act),
      .kill_if_i  (kill_if),
      .dc_miss_i  (dc_miss_i),
      .dc_tid_i   (dc_miss_tid_i),
      .flush_o    (flush_o)
   );

   assign active_tid_o  = act;
   assign fetch_valid_o = run;
   assign fetch_pc_o    = pc_t[act];

   a_r7_runner_free: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid_o |-> !parked[active_tid_o]);
   a_r3_ic_flush: assert property (@(posedge clk) disable iff (!rst_n)
      ic_miss_i && fetch_valid_o |-> flush_o[0]);
   a_r11_idle_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid_o |-> !flush_o[0]);
   a_r9_other_dc_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid_o && dc_miss_i && dc_miss_tid_i != active_tid_o && !ic_miss_i
      |=> fetch_valid_o && active_tid_o == $past(active_tid_o));
endmodule

// File: tb/test_cgmt_switch_ctrl.sv
module test_cgmt_switch_ctrl;
   localparam int PW = 16;
   localparam int ST = 4;
   localparam int RP0 = 'h0100;
   localparam int RP1 = 'h0800;
   localparam int NS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ic = 1'b0, dc = 1'b0, dtid = 1'b0;
   logic [PW-1:0] dpc = '0;
   logic [1:0] res = 2'b00;
   logic act_tid, fvalid;
   logic [PW-1:0] fpc;
   logic [NS-1:0] flush;

   int nchk = 0, nerr = 0;
   bit done = 0;

   // bench model state
   int mact, mrun;
   int mpc [2];
   int mblk [2];
   int mv [NS];
   int mt [NS];

   always #10 clk = ~clk;

   cgmt_switch_ctrl #(
      .PC_W(PW), .PC_STEP(ST),
      .RESET_PC0(PW'(RP0)), .RESET_PC1(PW'(RP1)), .NSTG(NS)
   ) i_cgmt_switch_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ic_miss_i(ic), .dc_miss_i(dc), .dc_miss_tid_i(dtid), .dc_miss_pc_i(dpc),
      .resolve_i(res),
      .active_tid_o(act_tid), .fetch_valid_o(fvalid), .fetch_pc_o(fpc), .flush_o(flush)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int a, input int e);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, a, e);
      end
   endtask

   // one cycle: drive at negedge, compare, advance model, wait next negedge
   task automatic cyc(input bit ic_, input bit dc_, input bit dt_, input int dp_,
                      input bit [1:0] r_, input string tag);
      int ef, nb [2], npc [2], nact, nrun, nv [NS], nt [NS];
      bit dca, sw;
      ic = ic_; dc = dc_; dtid = dt_; dpc = PW'(dp_); res = r_;
      #2;
      dca = dc_ && (dt_ == mact[0]);
      ef = 0;
      if (mrun != 0 && (ic_ || dca)) ef |= 1;
      for (int k = 1; k < NS; k++)
         if (mv[k] != 0 && dc_ && mt[k] == int'(dt_)) ef |= (1 << k);
      chk(fvalid == mrun[0], tag, "fetch_valid", fvalid, mrun);
      if (mrun != 0) begin
         chk(act_tid == mact[0], tag, "active_tid", act_tid, mact);
         chk(int'(fpc) == mpc[mact], tag, "fetch_pc", fpc, mpc[mact]);
      end
      chk(int'(flush) == ef, tag, "flush", flush, ef);
      sw = (mrun != 0) && (ic_ || dca);
      for (int t = 0; t < 2; t++) begin
         bit setb;
         setb = (dc_ && int'(dt_) == t) || (mrun != 0 && mact == t && ic_);
         nb[t] = (setb || (mblk[t] != 0 && !r_[t])) ? 1 : 0;
         if (dc_ && int'(dt_) == t) npc[t] = dp_;
         else if (mrun != 0 && mact == t && !ic_) npc[t] = (mpc[t] + ST) & 'hFFFF;
         else npc[t] = mpc[t];
      end
      nact = mact; nrun = mrun;
      if (mrun != 0) begin
         if (sw) begin
            if (nb[1-mact] == 0) nact = 1 - mact;
            else nrun = 0;
         end
      end else if (nb[1-mact] == 0) begin
         nact = 1 - mact; nrun = 1;
      end else if (nb[mact] == 0) nrun = 1;
      nv[0] = 0; nt[0] = 0;
      nv[1] = (mrun != 0 && (ef & 1) == 0) ? 1 : 0; nt[1] = mact;
      for (int k = 2; k < NS; k++) begin
         nv[k] = (mv[k-1] != 0 && ((ef >> (k-1)) & 1) == 0) ? 1 : 0;
         nt[k] = mt[k-1];
      end
      mact = nact; mrun = nrun;
      for (int t = 0; t < 2; t++) begin mpc[t] = npc[t]; mblk[t] = nb[t]; end
      for (int k = 0; k < NS; k++) begin mv[k] = nv[k]; mt[k] = nt[k]; end
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      mact = 0; mrun = 1; mpc[0] = RP0; mpc[1] = RP1; mblk[0] = 0; mblk[1] = 0;
      for (int k = 0; k < NS; k++) begin mv[k] = 0; mt[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, 2'b00, "R1 reset state");
      cyc(0, 0, 0, 0, 2'b00, "R2 step");
      cyc(0, 0, 0, 0, 2'b00, "R2 step");
      cyc(1, 0, 0, 0, 2'b00, "R3 icache miss t0");
      cyc(0, 1, 0, 'h104, 2'b00, "R9 R4 dcache miss inactive t0");
      cyc(0, 0, 0, 0, 2'b00, "R9 t1 continues");
      cyc(0, 0, 0, 0, 2'b00, "R2 t1 step");
      cyc(0, 0, 0, 0, 2'b01, "R7 resolve t0");
      cyc(0, 1, 1, 'h804, 2'b00, "R4 R6 dcache miss active t1");
      cyc(0, 0, 0, 0, 2'b00, "R5 t0 resumes at rewound pc");
      cyc(0, 0, 0, 0, 2'b00, "R2 t0 step");
      cyc(1, 1, 0, 'h104, 2'b00, "R8 combined miss t0");
      cyc(1, 0, 0, 0, 2'b00, "R11 icache miss while idle");
      cyc(0, 0, 0, 0, 2'b11, "R7 bubbles until resolve");
      cyc(0, 0, 0, 0, 2'b00, "R10 idle pick other thread");
      cyc(1, 0, 0, 0, 2'b00, "R3 icache miss t1");
      cyc(0, 0, 0, 0, 2'b00, "R8 saved pc is dcache pc");
      cyc(0, 1, 1, 'h7F0, 2'b00, "R9 dcache miss parked t1");
      cyc(1, 0, 0, 0, 2'b10, "R7 resolve same cycle as switch");
      cyc(0, 0, 0, 0, 2'b00, "R7 t1 selected");
      cyc(0, 0, 0, 0, 2'b00, "R5 t1 rewound pc");
      for (int i = 0; i < 600; i++) begin
         bit ri, rd, rt;
         bit [1:0] rr;
         int rp;
         ri = ($urandom % 8) == 0;
         rd = ($urandom % 10) == 0;
         rt = $urandom % 2;
         rr = 2'($urandom % 4) & {($urandom % 3) == 0, ($urandom % 3) == 0};
         rp = int'($urandom % 'h4000) & ~(ST - 1);
         cyc(ri, rd, rt, rp, rr, "R4/R7 random mix");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule